// File: doc/BRIEF.md
# Address-space-tagged translation lookaside buffer

This block is a small, fully associative translation cache. Each lookup presents a virtual address, the identifier of the address space now running, and whether the access is a load or a store. One cycle later the block answers with a hit flag, the translated physical address, a protection-fault flag and a flag that reports more than one matching entry. The low twelve address bits are the byte offset within a 4 KB page and are never translated.

Each entry holds a virtual page number, an address-space tag, a flag that makes the entry shared by every address space, a per-bit ignore mask, a physical frame number and a store-permission flag. A set mask bit removes that page-number bit from the compare and copies it from the virtual address into the physical one, so a single entry can cover an aligned region of several pages. Entries are installed through a write port that either names a slot or leaves it to a rotating pointer. A miss is only reported: some external agent installs the missing entry and repeats the lookup.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit without fault, `rs_paddr[11:0]` equals bits 11..0 of the looked-up virtual address.
- R2: A non-shared entry matches only when its stored tag equals `lk_asid` and its page number equals `lk_vaddr[31:12]` on every unmasked bit; a differing tag gives a miss.
- R3: An entry installed with `wr_global`=1 matches for any value of `lk_asid`.
- R4: Page-number bit k with mask bit k set is left out of the compare, and physical address bit k+12 is then taken from the virtual address instead of the frame number.
- R5: On a hit, `rs_paddr[31:12]` is the entry's frame number on all unmasked bits.
- R6: A store (`lk_write`=1) that hits an entry installed with `wr_writable`=0 gives `rs_hit`=1, `rs_fault`=1 and `rs_paddr`=0; a load of the same entry hits without fault.
- R7: A lookup that matches no valid entry gives `rs_hit`=0, `rs_fault`=0, `rs_multi`=0 and `rs_paddr`=0; after the entry is installed the repeated lookup hits.
- R8: Reset clears every entry's valid flag and all result outputs; lookups after reset miss until entries are installed.
- R9: When two or more valid entries match, the one with the lowest slot number supplies the result and `rs_multi`=1.
- R10: The result of a lookup sampled at clock edge N appears after edge N with `rs_valid`=1 (`rs_valid`=0 after an edge with no lookup); a write sampled at edge N is seen by a lookup at edge N+1, while a lookup at edge N still sees the old contents.
- R11: A write with `wr_use_idx`=0 goes to a rotating slot pointer that starts at 0 after reset and advances by one (wrapping 15 to 0) per such write; writes with `wr_use_idx`=1 go to `wr_idx` and leave the pointer alone; a write with `wr_valid`=0 removes the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space tag |
| lk_write | input | 1 | 1 = store access, 0 = load |
| wr_en | input | 1 | Install an entry this cycle |
| wr_use_idx | input | 1 | 1 = use `wr_idx`, 0 = use rotating pointer |
| wr_idx | input | 4 | Target slot when `wr_use_idx`=1 |
| wr_valid | input | 1 | Valid flag of the new entry |
| wr_vpn | input | 20 | Virtual page number |
| wr_asid | input | 8 | Address-space tag |
| wr_global | input | 1 | Match in every address space |
| wr_mask | input | 20 | Page-number ignore mask |
| wr_pfn | input | 20 | Physical frame number |
| wr_writable | input | 1 | Stores permitted |
| rs_valid | output | 1 | Result of a lookup is present |
| rs_hit | output | 1 | A valid entry matched |
| rs_fault | output | 1 | Store to a non-writable entry |
| rs_multi | output | 1 | More than one entry matched |
| rs_paddr | output | 32 | Translated physical address |

## Verification
Every result is due exactly one clock edge after the lookup that caused it, and an installed entry is due to be visible at the edge after the one that wrote it. The bench drives all inputs on the falling edge, advances its behavioural model of the entry table on the rising edge in the same order as the requirements (answer from old contents, then apply the write), and compares all five result outputs at the next falling edge, so every cycle, including idle and reset cycles, is checked at the point where its result is due. Directed cycles place a write and a lookup of the same page on the same edge and on successive edges to pin down that ordering.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_VA_W    = 32;
  localparam int unsigned TLB_PA_W    = 32;
  localparam int unsigned TLB_OFF_W   = 12;
  localparam int unsigned TLB_ASID_W  = 8;
  localparam int unsigned TLB_ENTRIES = 16;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int unsigned N      = 16,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned PFN_W  = 20,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_use_idx,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_writable,
  output logic              e_valid [N],
  output logic [VPN_W-1:0]  e_vpn   [N],
  output logic [ASID_W-1:0] e_asid  [N],
  output logic              e_global[N],
  output logic [VPN_W-1:0]  e_mask  [N],
  output logic [PFN_W-1:0]  e_pfn   [N],
  output logic              e_wr    [N]
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] tgt;

  assign tgt = wr_use_idx ? wr_idx : rr_q;

  // valid flags and pointer carry reset; payload fields do not
  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
      for (int i = 0; i < int'(N); i++) e_valid[i] <= 1'b0;
    end else if (wr_en) begin
      e_valid[tgt] <= wr_valid;
      if (!wr_use_idx)
        rr_q <= (rr_q == IDX_W'(N-1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_vpn[tgt]    <= wr_vpn;
      e_asid[tgt]   <= wr_asid;
      e_global[tgt] <= wr_global;
      e_mask[tgt]   <= wr_mask;
      e_pfn[tgt]    <= wr_pfn;
      e_wr[tgt]     <= wr_writable;
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N      = 16,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              e_valid [N],
  input  logic [VPN_W-1:0]  e_vpn   [N],
  input  logic [ASID_W-1:0] e_asid  [N],
  input  logic              e_global[N],
  input  logic [VPN_W-1:0]  e_mask  [N],
  output logic              any_hit,
  output logic              multi_hit,
  output logic [IDX_W-1:0]  sel_idx
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < int'(N); g++) begin : g_cmp
    logic vpn_eq, tag_eq;
    assign vpn_eq = (((lk_vpn ^ e_vpn[g]) & ~e_mask[g]) == '0);
    assign tag_eq = e_global[g] || (lk_asid == e_asid[g]);
    assign hit_vec[g] = e_valid[g] && vpn_eq && tag_eq;
  end

  logic [IDX_W:0] cnt;
  always_comb begin
    sel_idx = '0;
    cnt     = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel_idx = IDX_W'(i);
    end
    for (int i = 0; i < int'(N); i++) cnt = cnt + (IDX_W+1)'(hit_vec[i]);
  end

  assign any_hit   = |hit_vec;
  assign multi_hit = (cnt > (IDX_W+1)'(1));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W    = TLB_VA_W,
  parameter int unsigned PA_W    = TLB_PA_W,
  parameter int unsigned OFF_W   = TLB_OFF_W,
  parameter int unsigned ASID_W  = TLB_ASID_W,
  parameter int unsigned ENTRIES = TLB_ENTRIES,
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned PFN_W  = PA_W - OFF_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  input  logic              wr_en,
  input  logic              wr_use_idx,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_writable,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic              rs_fault,
  output logic              rs_multi,
  output logic [PA_W-1:0]   rs_paddr
);
  logic              e_valid [ENTRIES];
  logic [VPN_W-1:0]  e_vpn   [ENTRIES];
  logic [ASID_W-1:0] e_asid  [ENTRIES];
  logic              e_global[ENTRIES];
  logic [VPN_W-1:0]  e_mask  [ENTRIES];
  logic [PFN_W-1:0]  e_pfn   [ENTRIES];
  logic              e_wr    [ENTRIES];

  tlb_store #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) store_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_use_idx(wr_use_idx), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_mask(wr_mask), .wr_pfn(wr_pfn), .wr_writable(wr_writable),
    .e_valid(e_valid), .e_vpn(e_vpn), .e_asid(e_asid), .e_global(e_global),
    .e_mask(e_mask), .e_pfn(e_pfn), .e_wr(e_wr)
  );

  logic [VPN_W-1:0] lk_vpn;
  logic             any_hit, multi_hit;
  logic [IDX_W-1:0] sel;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) match_i (
    .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .e_valid(e_valid), .e_vpn(e_vpn), .e_asid(e_asid), .e_global(e_global),
    .e_mask(e_mask), .any_hit(any_hit), .multi_hit(multi_hit), .sel_idx(sel)
  );

  // masked page bits come from the virtual address, the rest from the frame
  logic [PFN_W-1:0] sel_mask, frame;
  logic             fault;
  assign sel_mask = PFN_W'(e_mask[sel]);
  assign frame    = (e_pfn[sel] & ~sel_mask) | (PFN_W'(lk_vpn) & sel_mask);
  assign fault    = any_hit && lk_write && !e_wr[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_fault <= 1'b0;
      rs_multi <= 1'b0;
      rs_paddr <= '0;
    end else begin
      rs_valid <= lk_valid;
      rs_hit   <= lk_valid && any_hit;
      rs_fault <= lk_valid && fault;
      rs_multi <= lk_valid && multi_hit;
      rs_paddr <= (lk_valid && any_hit && !fault) ? {frame, lk_vaddr[OFF_W-1:0]} : '0;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic [OFF_W-1:0] lk_off,
  input logic             lk_write,
  input logic             rs_valid,
  input logic             rs_hit,
  input logic             rs_fault,
  input logic             rs_multi,
  input logic [PA_W-1:0]  rs_paddr
);
  a_r10_result_due: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rs_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rs_valid);
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (!rs_hit || rs_fault || rs_paddr[OFF_W-1:0] == $past(lk_off)));
  a_r6_fault_on_store_hit: assert property (@(posedge clk) disable iff (rst)
    rs_fault |-> (rs_hit && rs_valid && rs_paddr == '0 && $past(lk_write)));
  a_r7_miss_clean: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && !rs_hit) |-> (!rs_fault && !rs_multi && rs_paddr == '0));
  a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rs_valid && !rs_hit && !rs_fault && !rs_multi));
  a_r9_multi_is_hit: assert property (@(posedge clk) disable iff (rst)
    rs_multi |-> rs_hit);
endmodule

bind tlb_xlate tlb_xlate_chk #(.PA_W(PA_W), .OFF_W(OFF_W)) chk_i (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_off(lk_vaddr[OFF_W-1:0]),
  .lk_write(lk_write), .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_fault(rs_fault),
  .rs_multi(rs_multi), .rs_paddr(rs_paddr)
);

// File: tb/tlb_xlate_tb_top.sv
`timescale 1ns/1ps
module tlb_xlate_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        lk_valid = 0, lk_write = 0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        wr_en = 0, wr_use_idx = 0, wr_valid = 0, wr_global = 0, wr_writable = 0;
  logic [3:0]  wr_idx = '0;
  logic [19:0] wr_vpn = '0, wr_mask = '0, wr_pfn = '0;
  logic [7:0]  wr_asid = '0;
  logic        rs_valid, rs_hit, rs_fault, rs_multi;
  logic [31:0] rs_paddr;

  tlb_xlate dut_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .lk_write(lk_write), .wr_en(wr_en), .wr_use_idx(wr_use_idx), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_mask(wr_mask), .wr_pfn(wr_pfn), .wr_writable(wr_writable),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_fault(rs_fault), .rs_multi(rs_multi),
    .rs_paddr(rs_paddr)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R8";

  // behavioural model of the table
  bit          mv[16], mg[16], mw[16];
  logic [19:0] mvpn[16], mmask[16], mpfn[16];
  logic [7:0]  masid[16];
  int          rr = 0;
  bit          ev, eh, ef, em;
  logic [31:0] ep;

  task automatic model_edge();
    if (rst) begin
      foreach (mv[i]) mv[i] = 0;
      rr = 0; ev = 0; eh = 0; ef = 0; em = 0; ep = '0;
    end else begin
      int first = -1;
      int cnt = 0;
      logic [19:0] vpn = lk_vaddr[31:12];
      ev = lk_valid; eh = 0; ef = 0; em = 0; ep = '0;
      if (lk_valid) begin
        for (int i = 0; i < 16; i++)
          if (mv[i] && (((vpn ^ mvpn[i]) & ~mmask[i]) == 20'h0) && (mg[i] || masid[i] == lk_asid)) begin
            cnt++;
            if (first < 0) first = i;
          end
        if (first >= 0) begin
          eh = 1; em = (cnt > 1);
          if (lk_write && !mw[first]) ef = 1;
          else ep = {(mpfn[first] & ~mmask[first]) | (vpn & mmask[first]), lk_vaddr[11:0]};
        end
      end
      if (wr_en) begin
        int t = wr_use_idx ? int'(wr_idx) : rr;
        mv[t] = wr_valid; mvpn[t] = wr_vpn; masid[t] = wr_asid; mg[t] = wr_global;
        mmask[t] = wr_mask; mpfn[t] = wr_pfn; mw[t] = wr_writable;
        if (!wr_use_idx) rr = (rr + 1) % 16;
      end
    end
  endtask

  task automatic compare();
    checks++;
    if (rs_valid !== ev || rs_hit !== eh || rs_fault !== ef || rs_multi !== em || rs_paddr !== ep) begin
      errors++;
      $display("FAIL %s: got v=%0b h=%0b f=%0b m=%0b pa=%h, expected v=%0b h=%0b f=%0b m=%0b pa=%h",
               cur_req, rs_valid, rs_hit, rs_fault, rs_multi, rs_paddr, ev, eh, ef, em, ep);
    end
  endtask

  task automatic cycle(input string req);
    cur_req = req;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    wr_en = 0; lk_valid = 0; lk_write = 0;
  endtask

  task automatic put(input bit use_idx, input int idx, input bit v, input logic [19:0] vpn,
                     input logic [7:0] asid, input bit g, input logic [19:0] mask,
                     input logic [19:0] pfn, input bit w);
    wr_en = 1; wr_use_idx = use_idx; wr_idx = 4'(idx); wr_valid = v; wr_vpn = vpn;
    wr_asid = asid; wr_global = g; wr_mask = mask; wr_pfn = pfn; wr_writable = w;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid, input bit w);
    lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_write = w;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    look(32'h1234_5678, 8'd5, 0);
    cycle("R8"); cycle("R8");             // reset cycles: outputs cleared
    rst = 0;
    look(32'h1234_5678, 8'd5, 0); cycle("R8");  // empty table misses
    cycle("R10");                          // idle cycle: no result
    // R11: first unindexed write lands in slot 0
    put(0, 0, 1, 20'h12345, 8'd5, 0, 20'h0, 20'hABCDE, 1); cycle("R11");
    look(32'h1234_5678, 8'd5, 0); cycle("R5");  // expect ABCDE678
    look(32'h1234_5FFF, 8'd5, 1); cycle("R1");
    look(32'h1234_5678, 8'd6, 0); cycle("R2");  // other tag misses
    look(32'h1234_4678, 8'd5, 0); cycle("R2");
    // R10: write and lookup on the same edge see old contents
    put(0, 0, 1, 20'h22222, 8'd5, 0, 20'h0, 20'h0BEEF, 1);
    look(32'h2222_2010, 8'd5, 0); cycle("R10");
    look(32'h2222_2010, 8'd5, 0); cycle("R10");
    // R3: shared entry
    put(1, 7, 1, 20'h00400, 8'd1, 1, 20'h0, 20'h77777, 1); cycle("R3");
    look(32'h0040_0ABC, 8'd9, 0); cycle("R3");
    look(32'h0040_0ABC, 8'd1, 0); cycle("R3");
    // R11: indexed write did not move pointer: next goes to slot 2
    put(0, 0, 1, 20'h55555, 8'd5, 0, 20'h0, 20'h66666, 1); cycle("R11");
    look(32'h5555_5000, 8'd5, 0); cycle("R11");
    put(1, 2, 0, 20'h0, 8'd0, 0, 20'h0, 20'h0, 0); cycle("R11");
    look(32'h5555_5000, 8'd5, 0); cycle("R11");  // removed
    // R4: masked entry covering 256 pages
    put(1, 4, 1, 20'h30000, 8'd3, 0, 20'h000FF, 20'h500FF, 1); cycle("R4");
    look(32'h300A_B123, 8'd3, 0); cycle("R4");   // expect 500AB123
    look(32'h3000_0004, 8'd3, 0); cycle("R4");
    look(32'h301A_B123, 8'd3, 0); cycle("R4");   // unmasked bit differs: miss
    // R6: read-only entry
    put(1, 5, 1, 20'h40000, 8'd3, 0, 20'h0, 20'h12121, 0); cycle("R6");
    look(32'h4000_0010, 8'd3, 1); cycle("R6");
    look(32'h4000_0010, 8'd3, 0); cycle("R6");
    // R9: two matching slots, 3 wins
    put(1, 9, 1, 20'h44444, 8'd2, 0, 20'h0, 20'h99999, 0); cycle("R9");
    put(1, 3, 1, 20'h44444, 8'd2, 1, 20'h0, 20'h33333, 1); cycle("R9");
    look(32'h4444_4444, 8'd2, 1); cycle("R9");
    look(32'h4444_4444, 8'd7, 0); cycle("R9");   // only shared slot 3 matches
    // R7: miss, install, retry
    look(32'h6000_0ABC, 8'd4, 0); cycle("R7");
    put(0, 0, 1, 20'h60000, 8'd4, 0, 20'h0, 20'h0CAFE, 1); cycle("R7");
    look(32'h6000_0ABC, 8'd4, 0); cycle("R7");
    // R11: wrap of the rotating pointer over 16 writes
    for (int i = 0; i < 16; i++) begin
      put(0, 0, 1, 20'h70000 + 20'(i), 8'd1, 0, 20'h0, 20'h80000 + 20'(i), 1); cycle("R11");
    end
    look(32'h6000_0ABC, 8'd4, 0); cycle("R11");
    // mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0)
        put($urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 4) != 0,
            20'h70000 + 20'($urandom_range(0, 7)), 8'($urandom_range(0, 3)),
            $urandom_range(0, 5) == 0, 20'((1 << $urandom_range(0, 2)) - 1),
            20'($urandom), $urandom_range(0, 1));
      if ($urandom_range(0, 4) != 0)
        look({20'h70000 + 20'($urandom_range(0, 7)), 12'($urandom)},
             8'($urandom_range(0, 3)), $urandom_range(0, 1));
      cycle("R2");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule